// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Tracker

This block sits inside one agent on a system bus whose address and data phases run independently of each other. Each local request that wins the address phase gets a transaction ID. The ID is built from the agent's fixed 4-bit identity and a 6-bit tag that is unique among this agent's open transactions. The tracker records the request's cache-block address and byte enables under that tag.

Coherence responses (shared vector, exclusive vector, L2-hit flag) follow the address phase. They are stored with the most recently issued request. Data beats can come back in any order. Each beat is matched to its entry by ID, and the entry is then retired, with its stored address, byte enables and coherence bits returned alongside the beat.

The request path and the retire path are both valid/ready streams. Back-pressure passes straight through the block: a request is accepted only when the bus issue port is ready and a tag is free. A data beat is consumed only when the retire consumer is ready.

Top module: `split_txn_tracker`

## Requirements
- R1: After a synchronous active-high reset, `out_count` is 0, no entry is open, and the first ID offered on `iss_id` carries tag 0.
- R2: `iss_id[9:6]` equals the parameter `MY_AGENT`. `iss_id[5:0]` is the lowest-numbered tag that is not open.
- R3: When all `DEPTH` entries are open, `req_ready` and `iss_valid` are both 0, whatever `req_valid` is.
- R4: `req_ready` is 1 only when `iss_ready` is 1 and a tag is free. A request opens an entry only in a cycle where `req_valid` and `req_ready` are both 1.
- R5: A beat with `dat_valid` whose `dat_id[9:6]` equals `MY_AGENT` and whose `dat_id[5:0]` names an open tag raises `ret_valid` in the same cycle. In that cycle `ret_tag` is the tag, `ret_addr` and `ret_byen` are the stored request fields, and `ret_data` equals `dat_data`.
- R6: A beat whose `dat_id[9:6]` differs from `MY_AGENT` has no effect. It raises neither `ret_valid` nor `prot_err`, and `out_count` is unchanged.
- R7: A beat accepted (`dat_valid` and `dat_ready`) with this agent's ID but a tag that is not open pulses `prot_err` in that cycle and changes no entry.
- R8: A cycle with `rsp_valid` stores `rsp_shd`, `rsp_exc` and `rsp_l2hit` into the entry of the most recently issued request, provided that entry is still open. A newly opened entry starts with all three cleared. The stored bits appear on `ret_shd`, `ret_exc` and `ret_l2hit` when that entry retires.
- R9: A tag is freed at the edge ending the cycle in which its beat is retired. It can be offered again from the next cycle on.
- R10: One allocation and one retirement can happen in the same cycle. `out_count` is then unchanged.
- R11: `dat_ready` follows `ret_ready`. While `ret_ready` is 0, a matching beat shows `ret_valid` but does not retire its entry.
- R12: `out_count` equals the number of open entries, updated one edge after each allocation or retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request accepted this cycle |
| req_addr | input | 35 | Cache-block address (address bits 39..5) |
| req_byen | input | 32 | Byte enables, bit i covers data byte i |
| req_cmd | input | 3 | Command code, passed to issue port |
| iss_valid | output | 1 | Address-phase request offered |
| iss_ready | input | 1 | Bus takes the address phase this cycle |
| iss_id | output | 10 | Transaction ID: agent [9:6], tag [5:0] |
| iss_addr | output | 35 | Issued block address |
| iss_byen | output | 32 | Issued byte enables |
| iss_cmd | output | 3 | Issued command |
| rsp_valid | input | 1 | Coherence response present |
| rsp_shd | input | 6 | Shared response vector |
| rsp_exc | input | 6 | Exclusive response vector |
| rsp_l2hit | input | 1 | L2-hit response |
| dat_valid | input | 1 | Data beat present |
| dat_ready | output | 1 | Data beat consumed |
| dat_id | input | 10 | Transaction ID of the beat |
| dat_data | input | 256 | Beat payload |
| ret_valid | output | 1 | Retirement offered |
| ret_ready | input | 1 | Retirement consumer ready |
| ret_tag | output | 6 | Tag being retired |
| ret_addr | output | 35 | Stored block address |
| ret_byen | output | 32 | Stored byte enables |
| ret_data | output | 256 | Beat payload |
| ret_shd | output | 6 | Stored shared vector |
| ret_exc | output | 6 | Stored exclusive vector |
| ret_l2hit | output | 1 | Stored L2-hit flag |
| prot_err | output | 1 | Beat for a tag that is not open |
| out_count | output | 7 | Number of open entries |

## Verification
The handshake outputs and the retire outputs (`req_ready`, `iss_valid`, `iss_id`, `ret_*`, `prot_err`, `dat_ready`) are combinational. They are due in the same cycle as the stimulus, so the bench drives on the falling edge and samples one time unit later, before the next rising edge. `out_count` and the entry contents change at the rising edge. The bench therefore samples them one time unit after that edge, and a response written in cycle N is looked for on a retirement in a later cycle. Every row of the vector table follows this drive, sample, edge, sample rhythm, so each result is read exactly in its due cycle.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int AGT_W  = 4;
  localparam int TAG_W  = 6;
  localparam int ID_W   = AGT_W + TAG_W;
  localparam int ADDR_W = 35;
  localparam int BE_W   = 32;
  localparam int DATA_W = BE_W * 8;
  localparam int RSP_W  = 6;
  localparam int CNT_W  = TAG_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   byen;
  } req_rec_t;

  typedef struct packed {
    logic [RSP_W-1:0] shd;
    logic [RSP_W-1:0] exc;
    logic             l2hit;
  } snoop_t;
endpackage

// File: rtl/stt_tag_alloc.sv
module stt_tag_alloc #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6
) (
  input  logic [DEPTH-1:0] open_i,
  output logic             any_free_o,
  output logic [TAG_W-1:0] free_tag_o
);
  always_comb begin
    any_free_o = 1'b0;
    free_tag_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!open_i[i]) begin
        any_free_o = 1'b1;
        free_tag_o = TAG_W'(i);
      end
    end
  end
endmodule

// File: rtl/stt_id_match.sv
module stt_id_match
  import stt_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int MY_AGENT = 2,
  localparam int IDXW    = $clog2(DEPTH)
) (
  input  logic [ID_W-1:0]  id_i,
  input  logic [DEPTH-1:0] open_i,
  output logic             own_o,
  output logic             hit_o,
  output logic [IDXW-1:0]  idx_o
);
  logic [TAG_W-1:0] tag;
  logic             in_range;

  assign tag      = id_i[TAG_W-1:0];
  assign own_o    = (id_i[ID_W-1:TAG_W] == AGT_W'(MY_AGENT));
  assign in_range = (int'(tag) < DEPTH);
  assign idx_o    = tag[IDXW-1:0];
  assign hit_o    = own_o && in_range && open_i[idx_o];
endmodule

// File: rtl/stt_entry_store.sv
module stt_entry_store
  import stt_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_en_i,
  input  logic [IDXW-1:0] alloc_idx_i,
  input  req_rec_t        alloc_rec_i,
  input  logic            rel_en_i,
  input  logic [IDXW-1:0] rel_idx_i,
  input  logic            snp_en_i,
  input  logic [IDXW-1:0] snp_idx_i,
  input  snoop_t          snp_i,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic [DEPTH-1:0] open_o,
  output req_rec_t        rd_rec_o,
  output snoop_t          rd_snp_o
);
  req_rec_t [DEPTH-1:0] rec_all;
  snoop_t   [DEPTH-1:0] snp_all;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic     v_q;
    req_rec_t rec_q;
    snoop_t   snp_q;
    logic     take, drop, note;

    assign take = alloc_en_i && (alloc_idx_i == IDXW'(g));
    assign drop = rel_en_i && (rel_idx_i == IDXW'(g));
    assign note = snp_en_i && (snp_idx_i == IDXW'(g)) && v_q && !drop;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (take) begin
        v_q <= 1'b1;
      end else if (drop) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        rec_q <= alloc_rec_i;
        snp_q <= '0;
      end else if (note) begin
        snp_q <= snp_i;
      end
    end

    assign open_o[g]  = v_q;
    assign rec_all[g] = rec_q;
    assign snp_all[g] = snp_q;
  end

  assign rd_rec_o = rec_all[rd_idx_i];
  assign rd_snp_o = snp_all[rd_idx_i];

  p_alloc_free_r9: assert property (@(posedge clk) disable iff (rst)
    alloc_en_i |-> !open_o[alloc_idx_i]);
  p_rel_open_r5: assert property (@(posedge clk) disable iff (rst)
    rel_en_i |-> open_o[rel_idx_i]);
  p_alloc_sets_r10: assert property (@(posedge clk) disable iff (rst)
    alloc_en_i |=> open_o[$past(alloc_idx_i)]);
  p_rel_clears_r9: assert property (@(posedge clk) disable iff (rst)
    rel_en_i |=> !open_o[$past(rel_idx_i)]);
endmodule

// File: rtl/split_txn_tracker.sv
module split_txn_tracker
  import stt_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int MY_AGENT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [34:0]   req_addr,
  input  logic [31:0]   req_byen,
  input  logic [2:0]    req_cmd,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [9:0]    iss_id,
  output logic [34:0]   iss_addr,
  output logic [31:0]   iss_byen,
  output logic [2:0]    iss_cmd,
  input  logic          rsp_valid,
  input  logic [5:0]    rsp_shd,
  input  logic [5:0]    rsp_exc,
  input  logic          rsp_l2hit,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [9:0]    dat_id,
  input  logic [255:0]  dat_data,
  output logic          ret_valid,
  input  logic          ret_ready,
  output logic [5:0]    ret_tag,
  output logic [34:0]   ret_addr,
  output logic [31:0]   ret_byen,
  output logic [255:0]  ret_data,
  output logic [5:0]    ret_shd,
  output logic [5:0]    ret_exc,
  output logic          ret_l2hit,
  output logic          prot_err,
  output logic [6:0]    out_count
);
  localparam int IDXW = $clog2(DEPTH);

  logic [DEPTH-1:0] open_v;
  logic             any_free;
  logic [TAG_W-1:0] free_tag;
  logic             own, hit;
  logic [IDXW-1:0]  hit_idx;
  logic             alloc_en, rel_en, dat_fire;
  logic [IDXW-1:0]  last_idx_q;
  logic [CNT_W-1:0] cnt_q;
  req_rec_t         new_rec, rd_rec;
  snoop_t           snp_in, rd_snp;

  stt_tag_alloc #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_alloc (
    .open_i(open_v), .any_free_o(any_free), .free_tag_o(free_tag));

  stt_id_match #(.DEPTH(DEPTH), .MY_AGENT(MY_AGENT)) u_match (
    .id_i(dat_id), .open_i(open_v), .own_o(own), .hit_o(hit), .idx_o(hit_idx));

  assign req_ready = iss_ready && any_free;
  assign iss_valid = req_valid && any_free;
  assign iss_id    = {AGT_W'(MY_AGENT), free_tag};
  assign iss_addr  = req_addr;
  assign iss_byen  = req_byen;
  assign iss_cmd   = req_cmd;
  assign alloc_en  = req_valid && req_ready;

  assign dat_ready = ret_ready;
  assign dat_fire  = dat_valid && dat_ready;
  assign ret_valid = dat_valid && hit;
  assign rel_en    = ret_valid && ret_ready;
  assign prot_err  = dat_fire && own && !hit;

  assign new_rec = '{addr: req_addr, byen: req_byen};
  assign snp_in  = '{shd: rsp_shd, exc: rsp_exc, l2hit: rsp_l2hit};

  stt_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .alloc_en_i(alloc_en), .alloc_idx_i(free_tag[IDXW-1:0]), .alloc_rec_i(new_rec),
    .rel_en_i(rel_en), .rel_idx_i(hit_idx),
    .snp_en_i(rsp_valid), .snp_idx_i(last_idx_q), .snp_i(snp_in),
    .rd_idx_i(hit_idx), .open_o(open_v), .rd_rec_o(rd_rec), .rd_snp_o(rd_snp));

  assign ret_tag   = dat_id[TAG_W-1:0];
  assign ret_addr  = rd_rec.addr;
  assign ret_byen  = rd_rec.byen;
  assign ret_data  = dat_data;
  assign ret_shd   = rd_snp.shd;
  assign ret_exc   = rd_snp.exc;
  assign ret_l2hit = rd_snp.l2hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_idx_q <= '0;
    end else if (alloc_en) begin
      last_idx_q <= free_tag[IDXW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({alloc_en, rel_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
  assign out_count = 7'(cnt_q);

  p_no_alloc_full_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(out_count) == DEPTH) |-> (!req_ready && !iss_valid));
  p_count_tracks_r12: assert property (@(posedge clk) disable iff (rst)
    int'(out_count) == $countones(open_v));
  p_iss_agent_r2: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (iss_id[9:6] == 4'(MY_AGENT)));
  p_foreign_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && dat_id[9:6] != 4'(MY_AGENT)) |-> (!ret_valid && !prot_err));
  p_err_no_ret_r7: assert property (@(posedge clk) disable iff (rst)
    prot_err |=> $stable(out_count) || $past(alloc_en));
  p_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !ret_ready && !alloc_en) |=> $stable(out_count));
endmodule

// File: tb/split_txn_tracker_tb_top.sv
module split_txn_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam logic [3:0] AG = 4'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_ready, iss_valid, iss_ready = 0;
  logic [34:0] req_addr = '0, iss_addr, ret_addr;
  logic [31:0] req_byen = '0, iss_byen, ret_byen;
  logic [2:0] req_cmd = '0, iss_cmd;
  logic [9:0] iss_id, dat_id = '0;
  logic rsp_valid = 0, rsp_l2hit = 0, dat_valid = 0, dat_ready, ret_valid, ret_ready = 0;
  logic [5:0] rsp_shd = '0, rsp_exc = '0, ret_tag, ret_shd, ret_exc;
  logic [255:0] dat_data = '0, ret_data;
  logic ret_l2hit, prot_err;
  logic [6:0] out_count;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_txn_tracker #(.DEPTH(DEPTH), .MY_AGENT(2)) dut_i (.*);

  typedef struct packed {
    logic rq; logic ir; logic dv; logic [9:0] did; logic rr;
    logic rv; logic [5:0] shd; logic [5:0] exc; logic l2;
    logic e_rdy; logic [5:0] e_tag; logic e_rv; logic e_err; logic [6:0] e_cnt;
    logic [5:0] e_shd; logic [5:0] e_exc; logic e_l2;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,10'd0,  1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd0,1'b0,1'b0,7'd1, 6'h00,6'h00,1'b0},
    '{1'b1,1'b1,1'b0,10'd0,  1'b1, 1'b1,6'h04,6'h00,1'b1, 1'b1,6'd1,1'b0,1'b0,7'd2, 6'h00,6'h00,1'b0},
    '{1'b1,1'b0,1'b0,10'd0,  1'b1, 1'b1,6'h00,6'h08,1'b0, 1'b0,6'd2,1'b0,1'b0,7'd2, 6'h00,6'h00,1'b0},
    '{1'b0,1'b1,1'b1,10'd129,1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd2,1'b1,1'b0,7'd1, 6'h00,6'h08,1'b0},
    '{1'b1,1'b1,1'b0,10'd0,  1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd1,1'b0,1'b0,7'd2, 6'h00,6'h00,1'b0},
    '{1'b1,1'b1,1'b1,10'd128,1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd2,1'b1,1'b0,7'd2, 6'h04,6'h00,1'b1},
    '{1'b0,1'b1,1'b1,10'd193,1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd0,1'b0,1'b0,7'd2, 6'h00,6'h00,1'b0},
    '{1'b0,1'b1,1'b1,10'd133,1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd0,1'b0,1'b1,7'd2, 6'h00,6'h00,1'b0},
    '{1'b0,1'b1,1'b1,10'd129,1'b0, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd0,1'b1,1'b0,7'd2, 6'h00,6'h00,1'b0},
    '{1'b0,1'b1,1'b1,10'd129,1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd0,1'b1,1'b0,7'd1, 6'h00,6'h00,1'b0},
    '{1'b1,1'b1,1'b0,10'd0,  1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd0,1'b0,1'b0,7'd2, 6'h00,6'h00,1'b0},
    '{1'b0,1'b1,1'b0,10'd0,  1'b1, 1'b1,6'h3f,6'h01,1'b0, 1'b1,6'd1,1'b0,1'b0,7'd2, 6'h00,6'h00,1'b0},
    '{1'b0,1'b1,1'b1,10'd128,1'b1, 1'b0,6'h00,6'h00,1'b0, 1'b1,6'd1,1'b1,1'b0,7'd1, 6'h3f,6'h01,1'b0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    req_valid = 0; dat_valid = 0; rsp_valid = 0; iss_ready = 1; ret_ready = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; idle();
    #1;
    chk(out_count == 0, "R1 count", out_count, 0);
    chk(iss_id[5:0] == 0 && req_ready, "R1 first tag", iss_id[5:0], 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = VEC[i].rq; iss_ready = VEC[i].ir; dat_valid = VEC[i].dv;
      dat_id = VEC[i].did; ret_ready = VEC[i].rr; rsp_valid = VEC[i].rv;
      rsp_shd = VEC[i].shd; rsp_exc = VEC[i].exc; rsp_l2hit = VEC[i].l2;
      req_addr = 35'(i + 7); dat_data = {8{32'(i * 3 + 1)}};
      #1;
      chk(req_ready == VEC[i].e_rdy, "R3 R4 req_ready", req_ready, VEC[i].e_rdy);
      if (VEC[i].rq) begin
        chk(iss_id == {AG, VEC[i].e_tag}, "R2 R9 iss_id", iss_id, {AG, VEC[i].e_tag});
      end
      chk(ret_valid == VEC[i].e_rv, "R5 R6 R11 ret_valid", ret_valid, VEC[i].e_rv);
      chk(prot_err == VEC[i].e_err, "R7 prot_err", prot_err, VEC[i].e_err);
      chk(dat_ready == VEC[i].rr, "R11 dat_ready", dat_ready, VEC[i].rr);
      if (VEC[i].e_rv) begin
        chk({ret_shd, ret_exc, ret_l2hit} == {VEC[i].e_shd, VEC[i].e_exc, VEC[i].e_l2},
            "R8 snoop bits", {ret_shd, ret_exc, ret_l2hit},
            {VEC[i].e_shd, VEC[i].e_exc, VEC[i].e_l2});
        chk(ret_data == dat_data, "R5 ret_data", ret_data[31:0], dat_data[31:0]);
      end
      @(posedge clk); #1;
      chk(out_count == VEC[i].e_cnt, "R10 R12 count", out_count, VEC[i].e_cnt);
    end

    @(negedge clk); idle(); rst = 1;
    @(negedge clk); rst = 0; #1;
    chk(out_count == 0, "R1 count after reset", out_count, 0);

    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      req_valid = 1; req_addr = 35'(100 + k); req_byen = 32'h1 << k;
      #1;
      chk(iss_id[5:0] == 6'(k), "R2 fill tag", iss_id[5:0], k);
      @(posedge clk);
    end
    @(negedge clk); #1;
    chk(out_count == 7'(DEPTH), "R12 full count", out_count, DEPTH);
    chk(!req_ready && !iss_valid, "R3 full stall", {req_ready, iss_valid}, 0);
    @(posedge clk); #1;
    chk(out_count == 7'(DEPTH), "R3 no alloc when full", out_count, DEPTH);

    @(negedge clk);
    req_valid = 0; dat_valid = 1; dat_id = {AG, 6'd5}; dat_data = {8{32'hA5A5_0005}};
    #1;
    chk(ret_valid && ret_tag == 6'd5, "R5 retire tag", ret_tag, 5);
    chk(ret_addr == 35'd105, "R5 ret_addr", ret_addr, 105);
    chk(ret_byen == 32'h20, "R5 ret_byen", ret_byen, 32'h20);
    chk(!req_ready, "R9 no reuse same cycle", req_ready, 0);
    @(posedge clk);
    @(negedge clk); dat_valid = 0; req_valid = 1; req_addr = 35'd55; #1;
    chk(req_ready && iss_id[5:0] == 6'd5, "R9 tag reused", iss_id[5:0], 5);
    @(posedge clk); #1;
    chk(out_count == 7'(DEPTH), "R12 refill count", out_count, DEPTH);
    @(negedge clk); idle();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule